// File: doc/BRIEF.md
# Byte-Stream Instruction Splitter for an 8080-Class Processor

This block sits between program memory and a decode or trace stage. It receives a stream of code bytes over a valid/ready handshake. It looks at each opcode byte to work out how many operand bytes come after it, which may be none, one or two. It collects those bytes and then presents one whole instruction as a record on a second valid/ready handshake.

Each record carries the following:
- the opcode;
- the length in bytes;
- the operand, assembled little-endian;
- the address of the opcode byte;
- the two three-bit fields of the opcode;
- a coarse instruction kind;
- a flag for opcodes the instruction set leaves undefined.

A local address counter tags each record. The counter then advances by the full length of the instruction when that record is consumed.

While a record is waiting to be taken, the byte input is stalled. A record is never released before every one of its operand bytes has arrived, however the input stream is paced.

Top module: `instr_splitter`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and `out_addr` equals the parameter `RESET_ADDR` (default 0).
- R2: `out_len` is 2 for the one-data-byte opcodes and 3 for the two-byte-operand opcodes. Every other opcode has length 1.
  - One data byte: `(op & 0xC7) == 0x06`, `(op & 0xC7) == 0xC6`, 0xD3 and 0xDB.
  - Two-byte operand: `(op & 0xCF) == 0x01`, 0x22, 0x2A, 0x32, 0x3A, 0xC3, 0xCD, `(op & 0xC7) == 0xC2` and `(op & 0xC7) == 0xC4`.
- R3: For length 3, `out_operand` is {second operand byte, first operand byte}. For length 2 it is {0x00, data byte}.
- R4: The opcode range 0x40 to 0x7F, except 0x76, gives `out_kind` = 1 (move). For these, `out_dst_op` = opcode bits 5:3 (destination) and `out_src` = bits 2:0 (source). Register codes 0 to 7 mean B, C, D, E, H, L, M, A. Opcode 0x76 gives `out_kind` = 2 (halt).
- R5: The opcode range 0x80 to 0xBF gives `out_kind` = 3 (ALU). Here `out_dst_op` = bits 5:3 selects ADD, ADC, SUB, SBB, ANA, XRA, ORA or CMP in code order, and `out_src` = bits 2:0.
- R6: An opcode of the form 0xC7 + 8n gives `out_kind` = 4 (restart), length 1, and `out_operand` = 8n.
- R7: The undefined opcodes 0x08, 0x10, 0x18, 0x20, 0x28, 0x30, 0x38, 0xCB, 0xD9, 0xDD, 0xED and 0xFD set `out_unknown`, with length 1 and `out_kind` = 0. The next byte is decoded as a new opcode.
- R8: Each record's `out_addr` is the previous record's address plus the previous length, modulo 2^`ADDR_W`.
- R9: Gaps in `in_valid` between the bytes of one instruction keep `out_valid` low until the last operand byte has been accepted.
- R10: While `out_valid` is 1 and `out_ready` is 0, the record stays stable and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Code byte present |
| in_ready | output | 1 | Block accepts a code byte |
| in_byte | input | 8 | Code byte |
| out_valid | output | 1 | Instruction record present |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 8 | Opcode byte |
| out_len | output | 2 | Instruction length, 1 to 3 |
| out_operand | output | 16 | Little-endian operand, or the restart target |
| out_addr | output | ADDR_W | Address of the opcode byte |
| out_dst_op | output | 3 | Opcode bits 5:3 |
| out_src | output | 3 | Opcode bits 2:0 |
| out_kind | output | 3 | 0 other, 1 move, 2 halt, 3 ALU, 4 restart |
| out_unknown | output | 1 | Undefined opcode |

## Verification
The bench builds the block with `ADDR_W` = 16 and `RESET_ADDR` = 0xFFF0. This puts the address wrap from 0xFFFF to 0x0000 within the first few instructions, so it does not take 65536 bytes of stream. Directed scenarios then cover:
- all three lengths;
- the move, halt, ALU and restart groups;
- the undefined opcodes;
- input gaps inside an instruction;
- a consumer that holds off the record.

// File: rtl/instr_splitter.sv
module instr_splitter #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_opcode,
  output logic [1:0]        out_len,
  output logic [15:0]       out_operand,
  output logic [ADDR_W-1:0] out_addr,
  output logic [2:0]        out_dst_op,
  output logic [2:0]        out_src,
  output logic [2:0]        out_kind,
  output logic              out_unknown
);

  localparam logic [2:0] K_OTHER = 3'd0, K_MOVE = 3'd1, K_HALT = 3'd2,
                         K_ALU = 3'd3, K_RST = 3'd4;

  function automatic logic [1:0] len_of(input logic [7:0] b);
    if ((b & 8'hC7) == 8'h06 || (b & 8'hC7) == 8'hC6 || b == 8'hD3 || b == 8'hDB)
      return 2'd2;
    if ((b & 8'hCF) == 8'h01 || b == 8'h22 || b == 8'h2A || b == 8'h32 ||
        b == 8'h3A || b == 8'hC3 || b == 8'hCD ||
        (b & 8'hC7) == 8'hC2 || (b & 8'hC7) == 8'hC4)
      return 2'd3;
    return 2'd1;
  endfunction

  logic [1:0]        phase;
  logic              vld_q;
  logic [7:0]        op_q, lo_q, hi_q;
  logic [ADDR_W-1:0] pc_q;
  logic [1:0]        cur_len;
  logic              take;

  assign in_ready = !vld_q;
  assign take     = in_valid && in_ready;
  assign cur_len  = len_of(phase == 2'd0 ? in_byte : op_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 2'd0;
      vld_q <= 1'b0;
      op_q  <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      pc_q  <= RESET_ADDR;
    end else begin
      if (vld_q && out_ready) begin
        vld_q <= 1'b0;
        pc_q  <= pc_q + {{(ADDR_W-2){1'b0}}, out_len};
      end
      if (take) begin
        case (phase)
          2'd0: begin
            op_q <= in_byte;
            lo_q <= '0;
            hi_q <= '0;
            if (cur_len == 2'd1) vld_q <= 1'b1;
            else                 phase <= 2'd1;
          end
          2'd1: begin
            lo_q <= in_byte;
            if (cur_len == 2'd2) begin
              vld_q <= 1'b1;
              phase <= 2'd0;
            end else begin
              phase <= 2'd2;
            end
          end
          default: begin
            hi_q  <= in_byte;
            vld_q <= 1'b1;
            phase <= 2'd0;
          end
        endcase
      end
    end
  end

  assign out_valid  = vld_q;
  assign out_opcode = op_q;
  assign out_len    = len_of(op_q);
  assign out_addr   = pc_q;
  assign out_dst_op = op_q[5:3];
  assign out_src    = op_q[2:0];

  assign out_unknown = ((op_q & 8'hC7) == 8'h00 && op_q != 8'h00) ||
                       op_q == 8'hCB || op_q == 8'hD9 || op_q == 8'hDD ||
                       op_q == 8'hED || op_q == 8'hFD;

  always_comb begin
    case (op_q[7:6])
      2'b01:   out_kind = (op_q == 8'h76) ? K_HALT : K_MOVE;
      2'b10:   out_kind = K_ALU;
      2'b11:   out_kind = (op_q[2:0] == 3'b111) ? K_RST : K_OTHER;
      default: out_kind = K_OTHER;
    endcase
  end

  always_comb begin
    if (out_len == 2'd3)      out_operand = {hi_q, lo_q};
    else if (out_len == 2'd2) out_operand = {8'h00, lo_q};
    else if (out_kind == K_RST) out_operand = {10'd0, op_q[5:3], 3'd0};
    else                      out_operand = 16'h0000;
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_opcode) &&
                                $stable(out_operand) && $stable(out_addr));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=>
      out_addr == $past(out_addr) + {{(ADDR_W-2){1'b0}}, $past(out_len)});

  p_unknown_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unknown |-> out_len == 2'd1 && out_kind == K_OTHER);

  p_rst_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == K_RST |->
      out_len == 2'd1 && out_operand[2:0] == 3'd0 && out_operand[15:6] == 10'd0);

  p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_len != 2'd0);

endmodule

// File: tb/instr_splitter_tb.sv
module instr_splitter_tb;
  localparam int PERIOD = 10;
  localparam int AW = 16;
  localparam logic [AW-1:0] START = 16'hFFF0;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic [7:0] in_byte = 0;
  logic in_ready, out_valid, out_unknown;
  logic [7:0] out_opcode;
  logic [1:0] out_len;
  logic [15:0] out_operand;
  logic [AW-1:0] out_addr;
  logic [2:0] out_dst_op, out_src, out_kind;

  int checks = 0, fails = 0;
  logic [AW-1:0] exp_addr = START;

  always #(PERIOD/2) clk = ~clk;

  instr_splitter #(.ADDR_W(AW), .RESET_ADDR(START)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
    .out_opcode(out_opcode), .out_len(out_len), .out_operand(out_operand),
    .out_addr(out_addr), .out_dst_op(out_dst_op), .out_src(out_src),
    .out_kind(out_kind), .out_unknown(out_unknown));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1; in_byte = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic pull(input string tag, input logic [7:0] op, input logic [1:0] len,
                      input logic [15:0] opnd, input logic [2:0] kind, input logic unk);
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    chk(tag, {out_opcode, 6'd0, out_len, out_operand, out_dst_op, out_src, out_kind, 4'd0, out_unknown},
             {op, 6'd0, len, opnd, op[5:3], op[2:0], kind, 4'd0, unk});
    chk({tag, " addr R8"}, 64'(out_addr), 64'(exp_addr));
    exp_addr = exp_addr + AW'(len);
    out_ready = 1;
    @(posedge clk); #1;
    out_ready = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 valid", 64'(out_valid), 0);
    chk("R1 ready", 64'(in_ready), 1);
    chk("R1 addr", 64'(out_addr), 64'(START));
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 7; i++) begin
      push(8'h21); push(8'h34); push(8'h12);
      pull("R8 R3 lxi", 8'h21, 2'd3, 16'h1234, 3'd0, 1'b0);
    end
    chk("R8 wrapped", 64'(exp_addr), 64'h0005);
  endtask

  task automatic t_lengths();
    push(8'h3E); push(8'h9A); pull("R2 R3 mvi", 8'h3E, 2'd2, 16'h009A, 3'd0, 1'b0);
    push(8'hFE); push(8'h01); pull("R2 cpi", 8'hFE, 2'd2, 16'h0001, 3'd0, 1'b0);
    push(8'hD3); push(8'h7F); pull("R2 out", 8'hD3, 2'd2, 16'h007F, 3'd0, 1'b0);
    push(8'hCD); push(8'hEF); push(8'hBE); pull("R2 R3 call", 8'hCD, 2'd3, 16'hBEEF, 3'd0, 1'b0);
    push(8'hFA); push(8'h00); push(8'h80); pull("R2 jm", 8'hFA, 2'd3, 16'h8000, 3'd0, 1'b0);
    push(8'h2A); push(8'h55); push(8'hAA); pull("R2 lhld", 8'h2A, 2'd3, 16'hAA55, 3'd0, 1'b0);
    push(8'h00); pull("R2 nop", 8'h00, 2'd1, 16'h0000, 3'd0, 1'b0);
    push(8'hC9); pull("R2 ret", 8'hC9, 2'd1, 16'h0000, 3'd0, 1'b0);
  endtask

  task automatic t_groups();
    push(8'h78); pull("R4 move a<-b", 8'h78, 2'd1, 16'h0000, 3'd1, 1'b0);
    push(8'h46); pull("R4 move b<-m", 8'h46, 2'd1, 16'h0000, 3'd1, 1'b0);
    push(8'h76); pull("R4 halt", 8'h76, 2'd1, 16'h0000, 3'd2, 1'b0);
    push(8'h80); pull("R5 add b", 8'h80, 2'd1, 16'h0000, 3'd3, 1'b0);
    push(8'hBF); pull("R5 cmp a", 8'hBF, 2'd1, 16'h0000, 3'd3, 1'b0);
    push(8'hC7); pull("R6 rst0", 8'hC7, 2'd1, 16'h0000, 3'd4, 1'b0);
    push(8'hDF); pull("R6 rst3", 8'hDF, 2'd1, 16'h0018, 3'd4, 1'b0);
    push(8'hFF); pull("R6 rst7", 8'hFF, 2'd1, 16'h0038, 3'd4, 1'b0);
  endtask

  task automatic t_unknown();
    push(8'h08); pull("R7 08", 8'h08, 2'd1, 16'h0000, 3'd0, 1'b1);
    push(8'h10); pull("R7 10", 8'h10, 2'd1, 16'h0000, 3'd0, 1'b1);
    push(8'hDD); pull("R7 dd", 8'hDD, 2'd1, 16'h0000, 3'd0, 1'b1);
    push(8'h06); push(8'h42); pull("R7 resume", 8'h06, 2'd2, 16'h0042, 3'd0, 1'b0);
  endtask

  task automatic t_gaps();
    push(8'hC3);
    repeat (3) @(negedge clk);
    chk("R9 after opcode", 64'(out_valid), 0);
    push(8'h11);
    repeat (3) @(negedge clk);
    chk("R9 after low", 64'(out_valid), 0);
    push(8'h22);
    pull("R9 jmp", 8'hC3, 2'd3, 16'h2211, 3'd0, 1'b0);
  endtask

  task automatic t_backpressure();
    push(8'h32); push(8'h0D); push(8'hF0);
    repeat (4) @(negedge clk);
    chk("R10 held valid", 64'(out_valid), 1);
    chk("R10 stall", 64'(in_ready), 0);
    chk("R10 opcode", 64'(out_opcode), 64'h32);
    chk("R10 operand", 64'(out_operand), 64'hF00D);
    pull("R10 sta", 8'h32, 2'd3, 16'hF00D, 3'd0, 1'b0);
  endtask

  initial begin
    #(PERIOD * 50000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_wrap();
    t_lengths();
    t_groups();
    t_unknown();
    t_gaps();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule